// File: doc/BRIEF.md
# Serial Receiver with Error Routing

This block receives asynchronous serial characters on a single line. An external baud tick clocks an internal oversampling counter. A falling level on the line starts the counter. The line is checked again at the half-bit point: a start is confirmed only if the line is still low there. The block then takes each data bit at the centre of its bit time, least significant bit first. An optional parity bit and one stop bit follow the data bits.

Each completed frame, good or bad, is copied into a receive buffer register. Three sticky error flags (parity, framing, overrun) record any problems. A mode input decides how errors are reported. In one setting a bad frame still raises the completion pulse. In the other setting a bad frame raises only the error pulse.

A read strobe tells the block that software has consumed the buffer. Dropping the enable input cancels any frame in progress without touching the buffer or the flags.

Top module: `serial_rx_router`

## Requirements
- R1: After reset, rx_data is 0, rx_full, all three error flags, irq_done and irq_err are 0.
- R2: A frame is one low start bit, DATA_W data bits with bit 0 first, an optional parity bit and a high stop bit. Each bit lasts OVS baud ticks. A clean frame loads rx_data, sets rx_full and gives a one-cycle irq_done pulse, with no irq_err.
- R3: par_mode 2'b00 or 2'b11 means no parity bit is present. 2'b01 means even parity: data plus parity bit hold an even number of ones. 2'b10 means odd parity. A mismatch sets st_parity_err.
- R4: A stop bit sampled as 0 sets st_frame_err.
- R5: The data of a frame with any error is still loaded into rx_data.
- R6: A frame with any error gives a one-cycle irq_err pulse. With err_route = 0 it also gives irq_done. With err_route = 1, irq_done is suppressed.
- R7: A frame that completes while rx_full is still set sets st_overrun, and rx_data takes the new frame.
- R8: The error flags stay set across later frames. A rd_strobe cycle with no frame completing clears all three flags and rx_full.
- R9: A low level on the line that has ended by the half-bit re-sample does not start a frame. It produces no pulse and changes no output.
- R10: Clearing rx_en during a frame stops reception at once. That frame produces no pulse and leaves rx_data and the flags unchanged. A frame sent after rx_en returns to 1 is received normally.
- R11: While rx_en is 0, activity on the line has no effect on any output.
- R12: The counter advances only on cycles where baud_tick is high, so frames are received correctly at any tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| err_route | input | 1 | 1: errored frames raise only irq_err |
| par_mode | input | 2 | Parity mode (none, even, odd) |
| baud_tick | input | 1 | Oversampling tick, OVS per bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | Buffer consumed; clears full and flags |
| rx_data | output | DATA_W | Receive buffer |
| rx_full | output | 1 | Buffer holds unread data |
| st_parity_err | output | 1 | Sticky parity error |
| st_frame_err | output | 1 | Sticky framing error |
| st_overrun | output | 1 | Sticky overrun error |
| irq_done | output | 1 | Reception-complete pulse |
| irq_err | output | 1 | Reception-error pulse |

## Verification
The bench builds the block with DATA_W = 8 and OVS = 8. The short bit time keeps each frame near a hundred cycles. That makes it affordable to sweep all 256 character values in every parity mode, with expected parity computed arithmetically. It also leaves room for directed error, overrun, glitch, abort and disabled-line cases, plus a slowed tick rate, all within one run.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PM_NONE = 2'b00;
  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        par_mode,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_perr,
  output logic              frame_ferr
);
  localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int BW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int HALF = OVS / 2;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              par_bit;
  logic              par_en_q;
  logic              par_odd_q;
  logic              at_half;
  logic              at_full;

  assign at_half = (cnt == CW'(HALF - 1));
  assign at_full = (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      frame_done <= 1'b0;
      frame_perr <= 1'b0;
      frame_ferr <= 1'b0;
      par_acc    <= 1'b0;
      par_bit    <= 1'b0;
      par_en_q   <= 1'b0;
      par_odd_q  <= 1'b0;
      if (rst) shreg <= '0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!line) state <= ST_START;
          end
          ST_START: begin
            if (at_half) begin
              cnt <= '0;
              if (!line) begin
                state     <= ST_DATA;
                bidx      <= '0;
                par_acc   <= 1'b0;
                par_en_q  <= parity_on(par_mode);
                par_odd_q <= (par_mode == PM_ODD);
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_full) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              if (bidx == BW'(DATA_W - 1)) state <= par_en_q ? ST_PAR : ST_STOP;
              else                         bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_full) begin
              cnt     <= '0;
              par_bit <= line;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_full) begin
              cnt        <= '0;
              frame_done <= 1'b1;
              frame_ferr <= !line;
              frame_perr <= par_en_q && ((par_acc ^ par_bit) != par_odd_q);
              state      <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_data = shreg;
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_perr,
  input  logic              frame_ferr,
  input  logic              rd_strobe,
  input  logic              err_route,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              perr_q,
  output logic              ferr_q,
  output logic              ovr_q,
  output logic              irq_done,
  output logic              irq_err
);
  logic take;
  logic ovr_now;
  logic any_err;

  always_comb begin
    take    = frame_done && en;
    ovr_now = buf_full && !rd_strobe;
    any_err = ovr_now || frame_perr || frame_ferr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      buf_full <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      ovr_q    <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      if (take) begin
        buf_data <= frame_data;
        buf_full <= 1'b1;
        perr_q   <= (perr_q && !rd_strobe) || frame_perr;
        ferr_q   <= (ferr_q && !rd_strobe) || frame_ferr;
        ovr_q    <= (ovr_q  && !rd_strobe) || ovr_now;
        irq_err  <= any_err;
        irq_done <= !any_err || !err_route;
      end else if (rd_strobe) begin
        buf_full <= 1'b0;
        perr_q   <= 1'b0;
        ferr_q   <= 1'b0;
        ovr_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_router.sv
module serial_rx_router #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              err_route,
  input  logic [1:0]        par_mode,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              st_parity_err,
  output logic              st_frame_err,
  output logic              st_overrun,
  output logic              irq_done,
  output logic              irq_err
);
  logic              line_s;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_perr;
  logic              f_ferr;

  srx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  srx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .tick       (baud_tick),
    .line       (line_s),
    .par_mode   (par_mode),
    .frame_done (f_done),
    .frame_data (f_data),
    .frame_perr (f_perr),
    .frame_ferr (f_ferr)
  );

  srx_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .frame_done (f_done),
    .frame_data (f_data),
    .frame_perr (f_perr),
    .frame_ferr (f_ferr),
    .rd_strobe  (rd_strobe),
    .err_route  (err_route),
    .buf_data   (rx_data),
    .buf_full   (rx_full),
    .perr_q     (st_parity_err),
    .ferr_q     (st_frame_err),
    .ovr_q      (st_overrun),
    .irq_done   (irq_done),
    .irq_err    (irq_err)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic err_route,
  input logic rd_strobe,
  input logic rx_full,
  input logic st_parity_err,
  input logic st_frame_err,
  input logic st_overrun,
  input logic irq_done,
  input logic irq_err
);
  logic any_flag;
  assign any_flag = st_parity_err || st_frame_err || st_overrun;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  assert_done_sets_full_R2: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> rx_full);

  assert_err_has_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> any_flag);

  assert_err_route_suppress_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_err && $past(err_route)) |-> !irq_done);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (irq_done || irq_err || (!any_flag && !rx_full)));

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!irq_done && !irq_err));
endmodule

bind serial_rx_router srx_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .rx_en         (rx_en),
  .err_route     (err_route),
  .rd_strobe     (rd_strobe),
  .rx_full       (rx_full),
  .st_parity_err (st_parity_err),
  .st_frame_err  (st_frame_err),
  .st_overrun    (st_overrun),
  .irq_done      (irq_done),
  .irq_err       (irq_err)
);

// File: tb/tb_serial_rx_router.sv
module tb_serial_rx_router;
  localparam int DW  = 8;
  localparam int OVS = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic          err_route = 1'b0;
  logic [1:0]    par_mode = 2'b00;
  logic          baud_tick;
  logic          rxd = 1'b1;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_full, st_parity_err, st_frame_err, st_overrun, irq_done, irq_err;

  int checks = 0;
  int errors = 0;
  int n_done = 0;
  int n_err  = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) tick_cnt <= 0;
    else tick_cnt <= tick_cnt + 1;
    if (irq_done) n_done <= n_done + 1;
    if (irq_err)  n_err  <= n_err + 1;
  end
  assign baud_tick = (tick_cnt == 0);

  serial_rx_router #(.DATA_W(DW), .OVS(OVS)) dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .err_route(err_route),
    .par_mode(par_mode), .baud_tick(baud_tick), .rxd(rxd),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .st_parity_err(st_parity_err), .st_frame_err(st_frame_err),
    .st_overrun(st_overrun), .irq_done(irq_done), .irq_err(irq_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (OVS * tick_div) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit bad_par, input bit stop_v);
    logic p;
    n_done = 0;
    n_err  = 0;
    hold_bit(1'b0);
    for (int i = 0; i < DW; i++) hold_bit(d[i]);
    if (par_mode == 2'b01 || par_mode == 2'b10) begin
      p = (par_mode == 2'b01) ? ^d : ~^d;
      hold_bit(bad_par ? ~p : p);
    end
    hold_bit(stop_v);
    rxd = 1'b1;
    repeat (2 * OVS * tick_div) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    eq("R1 rx_data", rx_data, 0);
    eq("R1 flags", {rx_full, st_parity_err, st_frame_err, st_overrun}, 0);
    eq("R1 irqs", {irq_done, irq_err}, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R3 exhaustive sweep over data in each parity mode
    for (int m = 0; m < 3; m++) begin
      par_mode = (m == 0) ? 2'b01 : (m == 1) ? 2'b10 : 2'b00;
      for (int d = 0; d < 256; d++) begin
        send(DW'(d), 1'b0, 1'b1);
        eq("R2 data", rx_data, d);
        eq("R2 full", rx_full, 1);
        eq("R2 done pulses", n_done, 1);
        eq("R2 err pulses", n_err, 0);
        eq("R3 no parity error", st_parity_err, 0);
        eq("R4 no frame error", st_frame_err, 0);
        do_read();
        eq("R8 full cleared", rx_full, 0);
      end
    end

    // R3 mode 2'b11 behaves as no parity
    par_mode = 2'b11;
    send(8'hA7, 1'b0, 1'b1);
    eq("R3 mode3 data", rx_data, 8'hA7);
    eq("R3 mode3 perr", st_parity_err, 0);
    do_read();

    // R3/R5/R6 bad parity, both routings
    par_mode = 2'b01;
    for (int r = 0; r < 2; r++) begin
      err_route = r[0];
      for (int d = 0; d < 32; d++) begin
        send(DW'(d * 7 + 3), 1'b1, 1'b1);
        eq("R5 errored data kept", rx_data, (d * 7 + 3) & 8'hFF);
        eq("R3 parity error", st_parity_err, 1);
        eq("R6 err pulse", n_err, 1);
        eq("R6 done pulse by route", n_done, r == 0 ? 1 : 0);
        do_read();
        eq("R8 flags cleared", {st_parity_err, st_frame_err, st_overrun}, 0);
      end
    end
    par_mode = 2'b10;
    err_route = 1'b1;
    send(8'h3C, 1'b1, 1'b1);
    eq("R3 odd parity error", st_parity_err, 1);
    do_read();

    // R4 framing error
    par_mode = 2'b00;
    send(8'h81, 1'b0, 1'b0);
    eq("R4 frame error", st_frame_err, 1);
    eq("R5 data kept on framing error", rx_data, 8'h81);
    eq("R6 routed err pulse", n_err, 1);
    eq("R6 routed done suppressed", n_done, 0);

    // R7/R8 sticky framing flag and overrun without a read
    send(8'h42, 1'b0, 1'b1);
    eq("R8 frame flag sticky", st_frame_err, 1);
    eq("R7 overrun", st_overrun, 1);
    eq("R7 newest data", rx_data, 8'h42);
    eq("R7 overrun err pulse", n_err, 1);
    do_read();
    eq("R8 read clears", {rx_full, st_parity_err, st_frame_err, st_overrun}, 0);

    // R9 glitch shorter than half a bit
    send(8'h55, 1'b0, 1'b1);
    keep = rx_data;
    n_done = 0;
    n_err = 0;
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * OVS) @(negedge clk);
    eq("R9 glitch no pulse", n_done + n_err, 0);
    eq("R9 glitch data", rx_data, keep);
    eq("R9 glitch full", rx_full, 1);
    do_read();

    // R10 abort mid-frame
    send(8'h99, 1'b0, 1'b1);
    keep = rx_data;
    n_done = 0;
    n_err = 0;
    hold_bit(1'b0);
    hold_bit(1'b1);
    hold_bit(1'b0);
    rx_en = 1'b0;
    rxd = 1'b1;
    repeat (12 * OVS) @(negedge clk);
    eq("R10 abort no pulse", n_done + n_err, 0);
    eq("R10 abort data", rx_data, keep);
    eq("R10 abort status", {rx_full, st_parity_err, st_frame_err, st_overrun}, 4'b1000);
    rx_en = 1'b1;
    repeat (2 * OVS) @(negedge clk);
    do_read();
    send(8'h6E, 1'b0, 1'b1);
    eq("R10 next frame data", rx_data, 8'h6E);
    eq("R10 next frame done", n_done, 1);
    do_read();

    // R11 disabled line ignored
    keep = rx_data;
    rx_en = 1'b0;
    send(8'h5A, 1'b0, 1'b0);
    eq("R11 disabled no pulse", n_done + n_err, 0);
    eq("R11 disabled data", rx_data, keep);
    eq("R11 disabled status", {rx_full, st_parity_err, st_frame_err, st_overrun}, 0);
    rx_en = 1'b1;
    repeat (2 * OVS) @(negedge clk);

    // R12 slower tick rate
    tick_div = 3;
    par_mode = 2'b01;
    repeat (6) @(negedge clk);
    send(8'hC3, 1'b0, 1'b1);
    eq("R12 slow tick data", rx_data, 8'hC3);
    eq("R12 slow tick done", n_done, 1);
    eq("R12 slow tick perr", st_parity_err, 0);
    do_read();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule